// File: doc/BRIEF.md
# Fractional-Rate Clock-Enable Divider

This block derives a single-cycle enable pulse from a fast system clock at an average rate of the clock divided by `divisor + frac_num/frac_den`. A serial transmitter or receiver clocks its bit logic with this pulse instead of a divided clock, so all logic stays in one clock domain. When the integer divisor alone cannot reach the wanted bit rate, the fractional part fixes the average. The block inserts a one-cycle stretch into some periods and spreads those stretches evenly, so each pulse stays within one input clock of its ideal instant.

A run input starts and stops the divider. Dropping run clears the period counter and the fractional phase. The next start therefore produces a fully predictable pulse train, beginning at the first period. The divisor, numerator and denominator are runtime inputs. They may change only while run is low.

Top module: `frac_ce_div`

## Requirements
- R1: While the reset input is low, and after reset is released with run held low, the tick output is low.
- R2: After any rising clock edge that samples run low, tick is low for the following cycle, and no tick occurs while run stays low.
- R3: After run goes high, the first tick is high during the cycle that begins with the L-th rising edge, counted from and including the first edge that samples run high. L is the length of period 0.
- R4: When frac_num is 0, every period is exactly divisor cycles long, whatever frac_den holds (including 0).
- R5: With 0 < frac_num < frac_den, period k (k = 0 is the first period after run rises) is divisor+1 cycles long when floor((k+1)*frac_num/frac_den) > floor(k*frac_num/frac_den), and divisor cycles long otherwise.
- R6: Each tick lasts exactly one clock cycle, and two ticks are never in adjacent cycles (divisor >= 3).
- R7: Lowering run and raising it again restarts the period sequence at k = 0, whatever phase the divider had reached.
- R8: Divisors from 3 up to 2^DIV_W-1 are supported, including a stretched period of 2^DIV_W cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run | input | 1 | High to run the divider; low clears its counter and phase |
| divisor | input | DIV_W | Integer part of the division ratio, at least 3 |
| frac_num | input | FRAC_W | Fraction numerator; 0 selects integer-only division |
| frac_den | input | FRAC_W | Fraction denominator, greater than frac_num when frac_num is nonzero |
| tick | output | 1 | One-cycle enable pulse at the divided rate |

## Verification
The divider runs in integer mode with a nonzero denominator and again with a zero denominator. This shows that the denominator is ignored when the numerator is zero. Three fractional settings follow: 1/3 at divisor 5, 5/7 at the minimum divisor 3, and 254/255 at the widest divisor. Each measured period is compared with the floor formula, which tells a correctly spread stretch apart from one placed in the wrong period or never applied. A restart taken part-way through a fractional sequence separates a phase that is cleared from one that carries over, and the idle window in between confirms that no tick leaks out while run is low.

// File: rtl/frac_ce_pkg.sv
`timescale 1ns/1ps
package frac_ce_pkg;

  // Default depth of the reset release synchronizer.
  localparam int unsigned FCD_RST_STAGES = 2;

  // Width that holds the sum of two values of width w without overflow.
  function automatic int unsigned fcd_sum_width(input int unsigned w);
    return w + 1;
  endfunction

endpackage

// File: rtl/frac_ce_rst_sync.sv
`timescale 1ns/1ps
module frac_ce_rst_sync #(
  parameter int unsigned STAGES = frac_ce_pkg::FCD_RST_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  // A one is shifted in from the bottom; the top stage is the released reset.
  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = 1'b1;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/frac_ce_period_cnt.sv
`timescale 1ns/1ps
module frac_ce_period_cnt #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] last_idx,
  output logic             wrap,
  output logic             tick_q
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;
  logic             tick_d;

  // The period ends on the cycle where the counter sits at its last index.
  always_comb begin
    wrap   = run && (cnt_q == last_idx);
    tick_d = wrap;
    if (!run) begin
      cnt_d = '0;
    end else if (wrap) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

endmodule

// File: rtl/frac_ce_phase_acc.sv
`timescale 1ns/1ps
module frac_ce_phase_acc #(
  parameter int unsigned FRAC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              advance,
  input  logic [FRAC_W-1:0] frac_num,
  input  logic [FRAC_W-1:0] frac_den,
  output logic              stretch
);

  localparam int unsigned SUM_W = frac_ce_pkg::fcd_sum_width(FRAC_W);

  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W-1:0] acc_d;
  logic [SUM_W-1:0]  sum;
  logic [SUM_W-1:0]  den_ext;
  logic [SUM_W-1:0]  rem;
  logic              num_zero;

  // The current period is stretched when the phase plus one numerator step
  // reaches the denominator; a zero numerator never stretches.
  always_comb begin
    num_zero = (frac_num == '0);
    den_ext  = {1'b0, frac_den};
    sum      = {1'b0, acc_q} + {1'b0, frac_num};
    rem      = sum - den_ext;
    stretch  = !num_zero && (sum >= den_ext);
    if (!run) begin
      acc_d = '0;
    end else if (advance) begin
      acc_d = stretch ? rem[FRAC_W-1:0] : sum[FRAC_W-1:0];
    end else begin
      acc_d = acc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end

endmodule

// File: rtl/frac_ce_div.sv
`timescale 1ns/1ps
module frac_ce_div #(
  parameter int unsigned DIV_W      = 8,
  parameter int unsigned FRAC_W     = 8,
  parameter int unsigned RST_STAGES = frac_ce_pkg::FCD_RST_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [DIV_W-1:0]  divisor,
  input  logic [FRAC_W-1:0] frac_num,
  input  logic [FRAC_W-1:0] frac_den,
  output logic              tick
);

  logic             rst_sync_n;
  logic             wrap;
  logic             stretch;
  logic [DIV_W-1:0] last_idx;

  frac_ce_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Period length is divisor, or divisor+1 when stretched; index is length-1.
  always_comb begin
    last_idx = divisor - DIV_W'(1) + DIV_W'(stretch);
  end

  frac_ce_period_cnt #(.DIV_W(DIV_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run      (run),
    .last_idx (last_idx),
    .wrap     (wrap),
    .tick_q   (tick)
  );

  frac_ce_phase_acc #(.FRAC_W(FRAC_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run      (run),
    .advance  (wrap),
    .frac_num (frac_num),
    .frac_den (frac_den),
    .stretch  (stretch)
  );

endmodule

// File: rtl/frac_ce_div_chk.sv
`timescale 1ns/1ps
module frac_ce_div_chk #(
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned FRAC_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_i,
  input logic [DIV_W-1:0]  divisor_i,
  input logic [FRAC_W-1:0] frac_num_i,
  input logic              tick_o
);

  logic [DIV_W:0] gap_q;
  logic           seen_q;
  logic [DIV_W:0] div_ext;

  assign div_ext = {1'b0, divisor_i};

  // Cycles elapsed since the last tick, or since the run started.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (!run_i) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (tick_o) begin
      gap_q  <= (DIV_W+1)'(1);
      seen_q <= 1'b1;
    end else begin
      gap_q  <= gap_q + (DIV_W+1)'(1);
    end
  end

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run_i) |-> !tick_o);

  // R5
  period_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && $past(run_i)) |-> (gap_q == div_ext || gap_q == div_ext + 1'b1));

  // R4
  integer_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && $past(run_i) && frac_num_i == '0) |-> (gap_q == div_ext));

  // R3
  first_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && $past(run_i) && !seen_q) |-> (gap_q == div_ext));

endmodule

bind frac_ce_div frac_ce_div_chk #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .run_i      (run),
  .divisor_i  (divisor),
  .frac_num_i (frac_num),
  .tick_o     (tick)
);

// File: tb/frac_ce_div_bench.sv
`timescale 1ns/1ps
module frac_ce_div_bench;

  localparam int DW = 8;
  localparam int FW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          run;
  logic [DW-1:0] divisor;
  logic [FW-1:0] frac_num;
  logic [FW-1:0] frac_den;
  logic          tick;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  frac_ce_div #(.DIV_W(DW), .FRAC_W(FW)) u_frac_ce_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .divisor  (divisor),
    .frac_num (frac_num),
    .frac_den (frac_den),
    .tick     (tick)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected length of period k, from the floor rule.
  function automatic int exp_len(input int d, input int n, input int den, input int k);
    if (n == 0) return d;
    return d + ((((k + 1) * n) / den > (k * n) / den) ? 1 : 0);
  endfunction

  // Counts falling edges until tick is seen high; 0 when it never comes.
  task automatic wait_tick(output int n);
    n = 0;
    for (int i = 1; i <= 600; i++) begin
      @(negedge clk);
      if (tick) begin
        n = i;
        return;
      end
    end
  endtask

  task automatic setup(input int d, input int n, input int den);
    @(negedge clk);
    run      = 1'b0;
    divisor  = DW'(d);
    frac_num = FW'(n);
    frac_den = FW'(den);
    @(negedge clk);
  endtask

  // Starts the divider and checks the given number of periods.
  task automatic run_periods(input string req, input int d, input int n,
                             input int den, input int count);
    int got;
    run = 1'b1;
    for (int k = 0; k < count; k++) begin
      wait_tick(got);
      check(req, got, exp_len(d, n, den, k));
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    run = 1'b0;
    divisor = DW'(5);
    frac_num = '0;
    frac_den = FW'(1);
    repeat (3) @(negedge clk);
    check("R1 tick in reset", int'(tick), 0);
    rst_n = 1'b1;
    begin
      int seen = 0;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (tick) seen++;
      end
      check("R1 tick after release", seen, 0);
    end
  endtask

  task automatic t_integer();
    setup(5, 0, 7);
    run_periods("R4 integer den7", 5, 0, 7, 6);
    setup(6, 0, 0);
    run_periods("R4 integer den0", 6, 0, 0, 4);
  endtask

  task automatic t_frac_third();
    setup(5, 1, 3);
    run_periods("R5 div5 1/3", 5, 1, 3, 9);
  endtask

  task automatic t_frac_min_div();
    setup(3, 5, 7);
    run_periods("R5 R6 div3 5/7", 3, 5, 7, 14);
  endtask

  task automatic t_wide();
    setup(255, 254, 255);
    run_periods("R8 div255 254/255", 255, 254, 255, 3);
  endtask

  task automatic t_restart();
    int got;
    int seen;
    setup(4, 2, 3);
    run_periods("R3 first periods", 4, 2, 3, 2);
    repeat (2) @(negedge clk);
    run = 1'b0;
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (tick) seen++;
    end
    check("R2 idle ticks", seen, 0);
    run = 1'b1;
    for (int k = 0; k < 4; k++) begin
      wait_tick(got);
      check("R7 restart phase", got, exp_len(4, 2, 3, k));
    end
    @(negedge clk);
    run = 1'b0;
  endtask

  initial begin
    t_reset();
    t_integer();
    t_frac_third();
    t_frac_min_div();
    t_wide();
    t_restart();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule